// File: doc/BRIEF.md
# Strobed Parallel Input Port with Buffer-Full Handshake

This block is one handshaked input port of a parallel peripheral interface. A peripheral drives a byte onto its data lines and pulses an active-low strobe. The port captures the byte, raises a buffer-full flag, and requests an interrupt from the CPU. The peripheral does nothing else to ask for service, and the CPU does nothing to arm the port. The CPU collects the byte through an active-low read strobe. The falling edge of that read withdraws the interrupt request. The rising edge, once the byte has been taken, empties the buffer.

The interrupt can only be raised while an enable bit is set. The enable is written by a bit set/reset command: a write pulse carries a 3-bit bit index and a value, and only one index reaches this port's enable. That index is 4 when the block is built as the first port and 2 when it is built as the second. Both strobes arrive with no timing relation to the system clock. Each passes through a synchroniser chain, and its edges are found by comparing the synchronised sample with the one taken a cycle earlier.

Top module: `strobed_in_port`

## Requirements
- R1: While the synchronised peripheral strobe is low, `cpu_data_o` follows `per_data_i` one cycle later. Once the synchronised strobe is high, `cpu_data_o` holds the last byte captured.
- R2: `buf_full_o` goes high SYNC_STAGES+1 cycles after `per_stb_ni` falls. It does not rise before then.
- R3: `buf_full_o` clears SYNC_STAGES+1 cycles after `cpu_rd_ni` rises. It stays high while `cpu_rd_ni` is low.
- R4: `irq_o` goes high one cycle after the condition "synchronised strobe high, buffer full and enable set" becomes true. After a strobe this is SYNC_STAGES+1 cycles after `per_stb_ni` rises.
- R5: `irq_o` clears SYNC_STAGES+1 cycles after `cpu_rd_ni` falls. It then stays low while the condition stays true, until that condition falls and rises again.
- R6: `irq_o` drops one cycle after the synchronised strobe goes low or the enable is cleared.
- R7: When `cmd_we_i` is high and `cmd_bit_i` equals the enable index (4 for PORT = SIP_PORT_A, 2 for SIP_PORT_B), the enable takes the value of `cmd_val_i` (1 sets, 0 clears). Commands to any other index leave it unchanged.
- R8: Reset (`rst_ni` low, asynchronous) clears the buffer-full flag, the interrupt request, the enable and the captured byte. During reset both strobes are taken as idle-high.
- R9: A new strobe while the buffer is full overwrites the captured byte and keeps `buf_full_o` high. If a strobe fall and a read rise are detected in the same cycle, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| per_data_i | input | DATA_W | Byte from the peripheral |
| per_stb_ni | input | 1 | Peripheral strobe, active low, asynchronous |
| cpu_rd_ni | input | 1 | CPU read strobe, active low, asynchronous |
| cpu_data_o | output | DATA_W | Captured byte presented to the CPU |
| cmd_we_i | input | 1 | Bit set/reset command write pulse |
| cmd_bit_i | input | 3 | Bit index addressed by the command |
| cmd_val_i | input | 1 | Value written by the command |
| buf_full_o | output | 1 | Input buffer holds an unread byte |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
Each strobe edge takes SYNC_STAGES+1 clock edges to reach the flags: SYNC_STAGES edges through the synchroniser and one edge in the flag register. A command write changes the enable after one edge, and the interrupt responds on the next edge. The bench drives every input just after a falling clock edge and keeps a behavioural model that is fed the same input samples at each rising edge. On every falling edge it compares `cpu_data_o`, `buf_full_o` and `irq_o` with that model. Directed checks then count exactly these latencies from the point of stimulus, and sample one edge before each change as well as at the change, so an early or late output fails.

// File: rtl/sip_pkg.sv
package sip_pkg;
   // synchronised strobe view: level plus single-cycle edge pulses
   typedef struct packed {
      logic lvl;
      logic rise;
      logic fall;
   } sip_edge_t;

   // which port of the pair this instance serves; picks the enable index
   typedef enum logic {
      SIP_PORT_A = 1'b0,
      SIP_PORT_B = 1'b1
   } sip_port_e;

   localparam int unsigned SIP_CMD_IDX_W = 3;
endpackage

// File: rtl/sip_edge_sync.sv
module sip_edge_sync #(
   parameter int unsigned STAGES = 2,
   parameter logic        IDLE   = 1'b1
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                async_i,
   output sip_pkg::sip_edge_t  edge_o
);
   logic [STAGES-1:0] chain_q;
   logic              last_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("sip_edge_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[0] <= IDLE;
            else         chain_q[0] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[i] <= IDLE;
            else         chain_q[i] <= chain_q[i-1];
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) last_q <= IDLE;
      else         last_q <= chain_q[STAGES-1];
   end

   assign edge_o.lvl  = chain_q[STAGES-1];
   assign edge_o.rise = chain_q[STAGES-1] & ~last_q;
   assign edge_o.fall = ~chain_q[STAGES-1] & last_q;
endmodule

// File: rtl/sip_data_latch.sv
module sip_data_latch #(
   parameter int unsigned W = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         load_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (W < 1) begin : g_bad_width
      $error("sip_data_latch: W must be at least 1");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q_o <= '0;
      else if (load_i) q_o <= d_i;
   end
endmodule

// File: rtl/sip_flag_ctl.sv
module sip_flag_ctl (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  sip_pkg::sip_edge_t stb_i,
   input  sip_pkg::sip_edge_t rd_i,
   input  logic               en_i,
   output logic               full_o,
   output logic               irq_o
);
   logic full_q, irq_q, req_q, req;

   // service condition: strobe back high, byte waiting, interrupt enabled
   assign req = stb_i.lvl & full_q & en_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         full_q <= 1'b0;
         irq_q  <= 1'b0;
         req_q  <= 1'b0;
      end else begin
         // a new strobe wins over a read completing in the same cycle
         if (stb_i.fall)     full_q <= 1'b1;
         else if (rd_i.rise) full_q <= 1'b0;

         // request is raised by the condition becoming true, withdrawn by the read fall
         if (!req)           irq_q <= 1'b0;
         else if (rd_i.fall) irq_q <= 1'b0;
         else if (!req_q)    irq_q <= 1'b1;

         req_q <= req;
      end
   end

   assign full_o = full_q;
   assign irq_o  = irq_q;

   p_full_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stb_i.fall |=> full_q);
   p_full_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (full_q && !rd_i.lvl) |=> full_q);
   p_full_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i.rise && !stb_i.fall) |=> !full_q);
   p_irq_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stb_i.rise && full_q && en_i && !rd_i.fall) |=> irq_q);
   p_irq_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_i.fall |=> !irq_q);
   p_irq_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!stb_i.lvl || !en_i) |=> !irq_q);
endmodule

// File: rtl/strobed_in_port.sv
module strobed_in_port #(
   parameter int unsigned        DATA_W      = 8,
   parameter int unsigned        SYNC_STAGES = 2,
   parameter sip_pkg::sip_port_e PORT        = sip_pkg::SIP_PORT_A
) (
   input  logic                             clk_i,
   input  logic                             rst_ni,
   input  logic [DATA_W-1:0]                per_data_i,
   input  logic                             per_stb_ni,
   input  logic                             cpu_rd_ni,
   output logic [DATA_W-1:0]                cpu_data_o,
   input  logic                             cmd_we_i,
   input  logic [sip_pkg::SIP_CMD_IDX_W-1:0] cmd_bit_i,
   input  logic                             cmd_val_i,
   output logic                             buf_full_o,
   output logic                             irq_o
);
   import sip_pkg::*;

   localparam logic [SIP_CMD_IDX_W-1:0] EN_IDX_A = SIP_CMD_IDX_W'(4);
   localparam logic [SIP_CMD_IDX_W-1:0] EN_IDX_B = SIP_CMD_IDX_W'(2);

   if (DATA_W < 1) begin : g_bad_width
      $error("strobed_in_port: DATA_W must be at least 1");
   end

   sip_edge_t stb_e, rd_e;
   logic      en_q, en_hit;

   sip_edge_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_stb_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .async_i(per_stb_ni), .edge_o(stb_e));

   sip_edge_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_rd_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .async_i(cpu_rd_ni), .edge_o(rd_e));

   sip_data_latch #(.W(DATA_W)) u_latch (
      .clk_i(clk_i), .rst_ni(rst_ni), .load_i(~stb_e.lvl),
      .d_i(per_data_i), .q_o(cpu_data_o));

   // enable index depends on which port of the pair is built
   if (PORT == SIP_PORT_A) begin : g_idx_a
      assign en_hit = cmd_we_i && (cmd_bit_i == EN_IDX_A);
   end else begin : g_idx_b
      assign en_hit = cmd_we_i && (cmd_bit_i == EN_IDX_B);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     en_q <= 1'b0;
      else if (en_hit) en_q <= cmd_val_i;
   end

   sip_flag_ctl u_flags (
      .clk_i(clk_i), .rst_ni(rst_ni), .stb_i(stb_e), .rd_i(rd_e),
      .en_i(en_q), .full_o(buf_full_o), .irq_o(irq_o));

   p_capture_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !stb_e.lvl |=> (cpu_data_o == $past(per_data_i)));
   p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stb_e.lvl |=> $stable(cpu_data_o));
   p_en_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_hit |=> (en_q == $past(cmd_val_i)));
   p_en_other_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_hit |=> $stable(en_q));
   p_overwrite_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (buf_full_o && stb_e.fall) |=> buf_full_o);
endmodule

// File: tb/strobed_in_port_test.sv
module strobed_in_port_test;
   import sip_pkg::*;

   localparam int W      = 8;
   localparam int SYNC   = 2;
   localparam int LAT    = SYNC + 1;
   localparam int EN_IDX = 4;

   logic         clk = 1'b0, rst_n = 1'b0;
   logic [W-1:0] pdata = '0;
   logic         stb_n = 1'b1, rd_n = 1'b1, we = 1'b0, val = 1'b0;
   logic [2:0]   bsel = '0;
   logic [W-1:0] rdata;
   logic         full, irq;
   int           n_run = 0, n_fail = 0, cyc = 0;

   always #10 clk = ~clk;

   strobed_in_port #(.DATA_W(W), .SYNC_STAGES(SYNC), .PORT(SIP_PORT_A)) uut (
      .clk_i(clk), .rst_ni(rst_n), .per_data_i(pdata), .per_stb_ni(stb_n),
      .cpu_rd_ni(rd_n), .cpu_data_o(rdata), .cmd_we_i(we), .cmd_bit_i(bsel),
      .cmd_val_i(val), .buf_full_o(full), .irq_o(irq));

   // behavioural reference: input history queues and flag bits
   bit           sq[$], rq[$];
   bit           m_full, m_irq, m_en, m_reqp;
   logic [W-1:0] m_data;

   task automatic model_reset();
      sq.delete(); rq.delete();
      for (int i = 0; i <= SYNC; i++) begin
         sq.push_back(1'b1); rq.push_back(1'b1);
      end
      m_full = 0; m_irq = 0; m_en = 0; m_reqp = 0; m_data = '0;
   endtask

   initial model_reset();

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) model_reset();
      else begin
         bit s_lvl, s_fall, r_fall, r_rise, req;
         s_lvl  = sq[1];
         s_fall = sq[0] && !sq[1];
         r_fall = rq[0] && !rq[1];
         r_rise = !rq[0] && rq[1];
         req    = s_lvl && m_full && m_en;
         if (!req)        m_irq = 0;
         else if (r_fall) m_irq = 0;
         else if (!m_reqp) m_irq = 1;
         m_reqp = req;
         if (s_fall)      m_full = 1;
         else if (r_rise) m_full = 0;
         if (!s_lvl) m_data = pdata;
         if (we && bsel == 3'(EN_IDX)) m_en = val;
         void'(sq.pop_front()); sq.push_back(stb_n);
         void'(rq.pop_front()); rq.push_back(rd_n);
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R1 data vs model", 32'(rdata), 32'(m_data));
         chk("R2/R3/R9 full vs model", 32'(full), 32'(m_full));
         chk("R4/R5/R6 irq vs model", 32'(irq), 32'(m_irq));
      end
   end

   always @(posedge clk) begin
      if (cyc > 20000) begin
         n_fail++;
         $display("FAIL R8 watchdog actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cmd(int idx, bit v);
      bsel = 3'(idx); val = v; we = 1'b1;
      tick(1);
      we = 1'b0;
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      chk("R8 reset full", 32'(full), 0);
      chk("R8 reset irq", 32'(irq), 0);
      cmd(EN_IDX, 1);

      pdata = 8'hA5; stb_n = 1'b0;
      tick(LAT - 1); chk("R2 full not early", 32'(full), 0);
      tick(1);       chk("R2 full set", 32'(full), 1);
      tick(1);       chk("R1 capture", 32'(rdata), 32'h A5);
      tick(2);       stb_n = 1'b1;
      tick(LAT - 1); chk("R4 irq not early", 32'(irq), 0);
      tick(1);       chk("R4 irq set", 32'(irq), 1);
      pdata = 8'h3C;
      tick(2);       chk("R1 hold after strobe", 32'(rdata), 32'h A5);

      rd_n = 1'b0;
      tick(LAT - 1); chk("R5 irq before clear", 32'(irq), 1);
      tick(1);       chk("R5 irq cleared", 32'(irq), 0);
                     chk("R3 full kept during read", 32'(full), 1);
      tick(3);       chk("R5 irq stays low", 32'(irq), 0);
      rd_n = 1'b1;
      tick(LAT - 1); chk("R3 full before clear", 32'(full), 1);
      tick(1);       chk("R3 full cleared", 32'(full), 0);

      cmd(3, 0); cmd(2, 0);
      pdata = 8'h11; stb_n = 1'b0; tick(4); stb_n = 1'b1;
      tick(LAT);     chk("R7 other indices ignored", 32'(irq), 1);
      cmd(EN_IDX, 0);
                     chk("R6 irq one cycle after disable", 32'(irq), 1);
      tick(1);       chk("R6 irq drops on disable", 32'(irq), 0);
      cmd(EN_IDX, 1);
      tick(1);       chk("R7 enable set raises irq", 32'(irq), 1);

      pdata = 8'h5A; stb_n = 1'b0;
      tick(LAT);     chk("R9 full stays high", 32'(full), 1);
                     chk("R6 strobe low drops irq", 32'(irq), 0);
      tick(1);       chk("R9 overwrite", 32'(rdata), 32'h5A);
      stb_n = 1'b1;
      tick(LAT);     chk("R4 irq after second strobe", 32'(irq), 1);

      rst_n = 1'b0;
      tick(1);       chk("R8 mid reset full", 32'(full), 0);
                     chk("R8 mid reset irq", 32'(irq), 0);
                     chk("R8 mid reset data", 32'(rdata), 0);
      rst_n = 1'b1;
      tick(1);
      pdata = 8'h77; stb_n = 1'b0; tick(2); stb_n = 1'b1;
      tick(LAT + 1); chk("R2 full after reset", 32'(full), 1);
                     chk("R8 enable cleared by reset", 32'(irq), 0);
      rd_n = 1'b0; tick(2); rd_n = 1'b1;
      tick(LAT + 1); chk("R3 full cleared after read", 32'(full), 0);

      cmd(EN_IDX, 1);
      for (int i = 0; i < 12; i++) begin
         pdata = 8'(8'h13 * i + 8'h07);
         stb_n = 1'b0; tick(1 + i % 3);
         stb_n = 1'b1; tick(i % 5);
         if (i == 7) cmd(EN_IDX, 0);
         if (i == 9) cmd(EN_IDX, 1);
         rd_n = 1'b0;  tick(1 + i % 2);
         rd_n = 1'b1;  tick(i % 4);
      end
      tick(LAT + 2);
      chk("R3 idle after traffic", 32'(full), 0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule